// File: doc/BRIEF.md
# Bridge Address Window Translator

This block sits between a parent bus and a child bus that has four address spaces: memory, I/O, configuration and special. Each child space owns at most one window. A window records where it sits on the parent side, where it lands on the child side, how many bytes it spans, and which parent space tag applies to traffic that crosses it. Software, or an init sequencer, loads each window once through a small write port. Two cases raise a one-cycle error pulse: a second load of a window that is already configured, and a load that names a space index that does not exist.

A downstream access from the parent gives an address and a byte count. The block claims the access only when the whole span fits inside a configured window. It then reports which child space was hit and the translated child address. An access that fits no window stays unclaimed and reports zero bytes.

An upstream DMA request from the child side is forwarded to the parent unchanged only when it names the memory space and does not touch the bridge's own memory window on the child side. A refused request raises an error pulse that gives the reason.

Top module: `win_bridge_xlat`

## Requirements
- R1: After reset every window has size zero (unconfigured), no downstream access is claimed, and all outputs are zero. A window whose size is zero is never matched.
- R2: A write with `cfgValid` high and `cfgIdx` in 0..3 to a window whose size is zero stores the parent base, child base, size and parent tag. The new window is in effect for requests presented on the following cycle. Space codes are 0 memory, 1 I/O, 2 configuration, 3 special.
- R3: A write whose `cfgIdx` (0..3) names a window of nonzero size leaves the table unchanged and pulses `errDup` on the cycle after the write.
- R4: A write with `cfgIdx` in 4..7 leaves the table unchanged and pulses `errSpace` on the cycle after the write.
- R5: A downstream access at address A with N bytes matches a window only when A is at least the parent base and A+N is at most parent base plus size. Both sums are taken one bit wider than the address, so they never wrap.
- R6: When several windows match, the lowest space code wins.
- R7: On a match, one cycle after `dnValid` the block sets `dnClaim` high, `dnSpace` to the window's space code, `dnBytes` to N, and `dnChildAddr` to (A − parent base + child base) modulo 2^ADDR_W.
- R8: A downstream access that matches no window gives `dnClaim` low with `dnBytes`, `dnChildAddr` and `dnSpace` all zero one cycle later.
- R9: An upstream request with `upSpace` not equal to 0 (memory) is not forwarded and pulses `errDmaSpace` one cycle later.
- R10: An upstream memory request is refused with an `errSelfDma` pulse one cycle later when the memory window is configured and either A or A+N lies in [child base, child base + size], inclusive at both ends.
- R11: An accepted upstream request gives `upFwd` high, `upParentAddr` equal to A, and `upParentTag` equal to the memory window's stored tag one cycle later. A refused request drives all three to zero.
- R12: In a cycle with no valid request on a port, that port's claim, forward and error outputs are low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Window write strobe |
| cfgIdx | input | 3 | Space index of the write |
| cfgParentBase | input | ADDR_W | Parent-side base |
| cfgChildBase | input | ADDR_W | Child-side base |
| cfgSize | input | ADDR_W | Window size in bytes |
| cfgTag | input | TAG_W | Parent space tag |
| dnValid | input | 1 | Downstream request strobe |
| dnAddr | input | ADDR_W | Downstream parent address |
| dnCount | input | CNT_W | Downstream byte count |
| dnClaim | output | 1 | Access claimed |
| dnSpace | output | 2 | Child space of the claim |
| dnChildAddr | output | ADDR_W | Translated child address |
| dnBytes | output | CNT_W | Bytes transferred |
| upValid | input | 1 | Upstream DMA strobe |
| upSpace | input | 2 | Child space of the DMA |
| upAddr | input | ADDR_W | DMA address |
| upCount | input | CNT_W | DMA byte count |
| upFwd | output | 1 | DMA forwarded to parent |
| upParentAddr | output | ADDR_W | Forwarded address |
| upParentTag | output | TAG_W | Parent space tag of forward |
| errDup | output | 1 | Duplicate window write pulse |
| errSpace | output | 1 | Invalid index write pulse |
| errDmaSpace | output | 1 | Non-memory DMA pulse |
| errSelfDma | output | 1 | DMA into own window pulse |

## Verification
The bench builds the block with ADDR_W=10, CNT_W=4 and TAG_W=3. With those values it can sweep every parent address, at several byte counts, for both the downstream and the upstream paths. One window ends exactly at the top of the address space, so the no-wrap end test is covered. The memory window's child range wraps past the top, and a fourth window overlaps the memory window, so the priority order is exercised. All expected claims, translations and refusals are computed from a window model in the bench.

// File: rtl/win_xlat_pkg.sv
package win_xlat_pkg;
  localparam int NUM_SPACE = 4;
  localparam int SPACE_W   = 2;
  localparam int IDX_W     = 3;

  typedef enum logic [SPACE_W-1:0] {
    SP_MEM     = 2'd0,
    SP_IO      = 2'd1,
    SP_CFG     = 2'd2,
    SP_SPECIAL = 2'd3
  } spaceT;

  typedef struct packed {
    logic               winWr;
    logic [SPACE_W-1:0] winSel;
    logic               upAccept;
  } ctlStrobeT;
endpackage

// File: rtl/win_xlat_ctrl.sv
module win_xlat_ctrl
  import win_xlat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgValid,
  input  logic [IDX_W-1:0]     cfgIdx,
  input  logic                 upValid,
  input  logic [SPACE_W-1:0]   upSpace,
  input  logic [NUM_SPACE-1:0] occupied,
  input  logic                 selfHit,
  output ctlStrobeT            strb,
  output logic                 errDup,
  output logic                 errSpace,
  output logic                 errDmaSpace,
  output logic                 errSelfDma
);
  localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(NUM_SPACE);

  logic idxOk, dupHit, memReq;

  always_comb begin
    idxOk         = cfgIdx < IDX_LIMIT;
    dupHit        = idxOk && occupied[cfgIdx[SPACE_W-1:0]];
    memReq        = upSpace == SP_MEM;
    strb.winWr    = cfgValid && idxOk && !dupHit;
    strb.winSel   = cfgIdx[SPACE_W-1:0];
    strb.upAccept = upValid && memReq && !selfHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errDup      <= 1'b0;
      errSpace    <= 1'b0;
      errDmaSpace <= 1'b0;
      errSelfDma  <= 1'b0;
    end else begin
      errDup      <= cfgValid && dupHit;
      errSpace    <= cfgValid && !idxOk;
      errDmaSpace <= upValid && !memReq;
      errSelfDma  <= upValid && memReq && selfHit;
    end
  end

  // R3: a write onto a configured window is flagged next cycle
  a_r3_dup_flag: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && cfgIdx < IDX_LIMIT && occupied[cfgIdx[SPACE_W-1:0]] |=> errDup);

  // R4: an out-of-range index is flagged next cycle
  a_r4_space_flag: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && cfgIdx >= IDX_LIMIT |=> errSpace && !errDup);

  // R9: a non-memory DMA is flagged next cycle
  a_r9_dma_space: assert property (@(posedge clk) disable iff (!rstN)
    upValid && upSpace != SP_MEM |=> errDmaSpace && !errSelfDma);
endmodule

// File: rtl/win_xlat_dp.sv
module win_xlat_dp
  import win_xlat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int TAG_W  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobeT            strb,
  input  logic [ADDR_W-1:0]    cfgParentBase,
  input  logic [ADDR_W-1:0]    cfgChildBase,
  input  logic [ADDR_W-1:0]    cfgSize,
  input  logic [TAG_W-1:0]     cfgTag,
  input  logic                 dnValid,
  input  logic [ADDR_W-1:0]    dnAddr,
  input  logic [CNT_W-1:0]     dnCount,
  input  logic [ADDR_W-1:0]    upAddr,
  input  logic [CNT_W-1:0]     upCount,
  output logic [NUM_SPACE-1:0] occupied,
  output logic                 selfHit,
  output logic                 dnClaim,
  output logic [SPACE_W-1:0]   dnSpace,
  output logic [ADDR_W-1:0]    dnChildAddr,
  output logic [CNT_W-1:0]     dnBytes,
  output logic                 upFwd,
  output logic [ADDR_W-1:0]    upParentAddr,
  output logic [TAG_W-1:0]     upParentTag
);
  localparam int SUM_W = ADDR_W + 1;

  logic [ADDR_W-1:0] pBase [NUM_SPACE];
  logic [ADDR_W-1:0] cBase [NUM_SPACE];
  logic [ADDR_W-1:0] wSize [NUM_SPACE];
  logic [TAG_W-1:0]  pTag  [NUM_SPACE];

  logic [NUM_SPACE-1:0] hit;
  logic [SUM_W-1:0]     dnStart, dnEnd, upStart, upEnd, memLo, memHi;
  logic                 found;
  logic [SPACE_W-1:0]   selIdx;
  logic [ADDR_W-1:0]    childCalc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SPACE; i++) begin
        pBase[i] <= '0;
        cBase[i] <= '0;
        wSize[i] <= '0;
        pTag[i]  <= '0;
      end
    end else if (strb.winWr) begin
      pBase[strb.winSel] <= cfgParentBase;
      cBase[strb.winSel] <= cfgChildBase;
      wSize[strb.winSel] <= cfgSize;
      pTag[strb.winSel]  <= cfgTag;
    end
  end

  assign dnStart = {1'b0, dnAddr};
  assign dnEnd   = dnStart + SUM_W'(dnCount);

  for (genvar g = 0; g < NUM_SPACE; g++) begin : gWin
    logic [SUM_W-1:0] winLo, winHi;
    assign winLo       = {1'b0, pBase[g]};
    assign winHi       = winLo + {1'b0, wSize[g]};
    assign occupied[g] = wSize[g] != '0;
    assign hit[g]      = occupied[g] && dnStart >= winLo && dnEnd <= winHi;

    // R3: a window changes only on an accepted write aimed at it
    a_r3_hold_win: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.winWr && strb.winSel == SPACE_W'(g)) |=>
        $stable(wSize[g]) && $stable(pBase[g]) && $stable(cBase[g]));
  end

  always_comb begin
    found  = 1'b0;
    selIdx = '0;
    for (int i = NUM_SPACE - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found  = 1'b1;
        selIdx = SPACE_W'(i);
      end
    end
    childCalc = dnAddr - pBase[selIdx] + cBase[selIdx];
  end

  assign upStart = {1'b0, upAddr};
  assign upEnd   = upStart + SUM_W'(upCount);
  assign memLo   = {1'b0, cBase[SP_MEM]};
  assign memHi   = memLo + {1'b0, wSize[SP_MEM]};
  assign selfHit = occupied[SP_MEM] &&
                   ((upStart >= memLo && upStart <= memHi) ||
                    (upEnd >= memLo && upEnd <= memHi));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dnClaim      <= 1'b0;
      dnSpace      <= '0;
      dnChildAddr  <= '0;
      dnBytes      <= '0;
      upFwd        <= 1'b0;
      upParentAddr <= '0;
      upParentTag  <= '0;
    end else begin
      dnClaim      <= dnValid && found;
      dnSpace      <= (dnValid && found) ? selIdx : '0;
      dnChildAddr  <= (dnValid && found) ? childCalc : '0;
      dnBytes      <= (dnValid && found) ? dnCount : '0;
      upFwd        <= strb.upAccept;
      upParentAddr <= strb.upAccept ? upAddr : '0;
      upParentTag  <= strb.upAccept ? pTag[SP_MEM] : '0;
    end
  end

  // R8: an unclaimed access reports nothing
  a_r8_unclaimed_zero: assert property (@(posedge clk) disable iff (!rstN)
    !dnClaim |-> dnBytes == '0 && dnChildAddr == '0 && dnSpace == '0);

  // R12: no request, no claim on the next cycle
  a_r12_idle_dn: assert property (@(posedge clk) disable iff (!rstN)
    !dnValid |=> !dnClaim);
endmodule

// File: rtl/win_bridge_xlat.sv
module win_bridge_xlat
  import win_xlat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic [2:0]        cfgIdx,
  input  logic [ADDR_W-1:0] cfgParentBase,
  input  logic [ADDR_W-1:0] cfgChildBase,
  input  logic [ADDR_W-1:0] cfgSize,
  input  logic [TAG_W-1:0]  cfgTag,
  input  logic              dnValid,
  input  logic [ADDR_W-1:0] dnAddr,
  input  logic [CNT_W-1:0]  dnCount,
  output logic              dnClaim,
  output logic [1:0]        dnSpace,
  output logic [ADDR_W-1:0] dnChildAddr,
  output logic [CNT_W-1:0]  dnBytes,
  input  logic              upValid,
  input  logic [1:0]        upSpace,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic [CNT_W-1:0]  upCount,
  output logic              upFwd,
  output logic [ADDR_W-1:0] upParentAddr,
  output logic [TAG_W-1:0]  upParentTag,
  output logic              errDup,
  output logic              errSpace,
  output logic              errDmaSpace,
  output logic              errSelfDma
);
  ctlStrobeT            strb;
  logic [NUM_SPACE-1:0] occupied;
  logic                 selfHit;

  win_xlat_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgIdx(cfgIdx),
    .upValid(upValid), .upSpace(upSpace), .occupied(occupied),
    .selfHit(selfHit), .strb(strb), .errDup(errDup), .errSpace(errSpace),
    .errDmaSpace(errDmaSpace), .errSelfDma(errSelfDma)
  );

  win_xlat_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TAG_W(TAG_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgParentBase(cfgParentBase),
    .cfgChildBase(cfgChildBase), .cfgSize(cfgSize), .cfgTag(cfgTag),
    .dnValid(dnValid), .dnAddr(dnAddr), .dnCount(dnCount),
    .upAddr(upAddr), .upCount(upCount), .occupied(occupied),
    .selfHit(selfHit), .dnClaim(dnClaim), .dnSpace(dnSpace),
    .dnChildAddr(dnChildAddr), .dnBytes(dnBytes), .upFwd(upFwd),
    .upParentAddr(upParentAddr), .upParentTag(upParentTag)
  );

  // R11: a forwarded DMA never coincides with a refusal
  a_r11_fwd_excl: assert property (@(posedge clk) disable iff (!rstN)
    upFwd |-> !errDmaSpace && !errSelfDma);

  // R10: a self-targeted refusal carries no forwarded address
  a_r10_self_quiet: assert property (@(posedge clk) disable iff (!rstN)
    errSelfDma |-> !upFwd && upParentAddr == '0);
endmodule

// File: tb/sim_win_bridge_xlat.sv
module sim_win_bridge_xlat;
  localparam int AW = 10;
  localparam int CW = 4;
  localparam int TW = 3;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgValid = 1'b0;
  logic [2:0] cfgIdx = '0;
  logic [AW-1:0] cfgParentBase = '0, cfgChildBase = '0, cfgSize = '0;
  logic [TW-1:0] cfgTag = '0;
  logic dnValid = 1'b0;
  logic [AW-1:0] dnAddr = '0;
  logic [CW-1:0] dnCount = '0;
  logic dnClaim;
  logic [1:0] dnSpace;
  logic [AW-1:0] dnChildAddr;
  logic [CW-1:0] dnBytes;
  logic upValid = 1'b0;
  logic [1:0] upSpace = '0;
  logic [AW-1:0] upAddr = '0;
  logic [CW-1:0] upCount = '0;
  logic upFwd;
  logic [AW-1:0] upParentAddr;
  logic [TW-1:0] upParentTag;
  logic errDup, errSpace, errDmaSpace, errSelfDma;

  int nChecks = 0;
  int nFails = 0;
  int mPb[4], mCb[4], mSz[4], mTag[4];

  win_bridge_xlat #(.ADDR_W(AW), .CNT_W(CW), .TAG_W(TW)) u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic clearModel();
    for (int i = 0; i < 4; i++) begin
      mPb[i] = 0; mCb[i] = 0; mSz[i] = 0; mTag[i] = 0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    clearModel();
  endtask

  task automatic doCfg(input int idx, input int pb, input int cb, input int sz, input int tag);
    int expDup, expSp;
    expSp  = (idx > 3) ? 1 : 0;
    expDup = (idx <= 3 && mSz[idx] != 0) ? 1 : 0;
    cfgValid = 1'b1; cfgIdx = 3'(idx);
    cfgParentBase = AW'(pb); cfgChildBase = AW'(cb); cfgSize = AW'(sz); cfgTag = TW'(tag);
    @(negedge clk);
    cfgValid = 1'b0;
    chk(expDup ? "R3" : "R2", "errDup", int'(errDup), expDup);
    chk(expSp ? "R4" : "R2", "errSpace", int'(errSpace), expSp);
    if (!expSp && !expDup) begin
      mPb[idx] = pb; mCb[idx] = cb; mSz[idx] = sz; mTag[idx] = tag;
    end
  endtask

  task automatic doDn(input int a, input int n, input string tagHint);
    int claim, sp, ca;
    claim = 0; sp = 0; ca = 0;
    for (int i = 3; i >= 0; i--)
      if (mSz[i] != 0 && a >= mPb[i] && a + n <= mPb[i] + mSz[i]) begin
        claim = 1; sp = i; ca = (a - mPb[i] + mCb[i]) & AMASK;
      end
    dnValid = 1'b1; dnAddr = AW'(a); dnCount = CW'(n);
    @(negedge clk);
    dnValid = 1'b0;
    if (tagHint != "") begin
      chk(tagHint, "dnClaim", int'(dnClaim), claim);
      chk(tagHint, "dnSpace", int'(dnSpace), sp);
    end else if (claim) begin
      chk("R7", "dnClaim", int'(dnClaim), 1);
      chk("R7", "dnSpace", int'(dnSpace), sp);
      chk("R7", "dnChildAddr", int'(dnChildAddr), ca);
      chk("R7", "dnBytes", int'(dnBytes), n);
    end else begin
      chk("R8", "dnClaim", int'(dnClaim), 0);
      chk("R8", "dnBytes/addr", int'(dnBytes) + int'(dnChildAddr), 0);
    end
  endtask

  task automatic doUp(input int sp, input int a, input int n);
    int eSp, eSelf, eFwd, lo, hi;
    lo = mCb[0]; hi = mCb[0] + mSz[0];
    eSp   = (sp != 0) ? 1 : 0;
    eSelf = (!eSp && mSz[0] != 0 &&
             ((a >= lo && a <= hi) || (a + n >= lo && a + n <= hi))) ? 1 : 0;
    eFwd  = (!eSp && !eSelf) ? 1 : 0;
    upValid = 1'b1; upSpace = 2'(sp); upAddr = AW'(a); upCount = CW'(n);
    @(negedge clk);
    upValid = 1'b0;
    chk("R9", "errDmaSpace", int'(errDmaSpace), eSp);
    chk("R10", "errSelfDma", int'(errSelfDma), eSelf);
    chk("R11", "upFwd", int'(upFwd), eFwd);
    chk("R11", "upParentAddr", int'(upParentAddr), eFwd ? a : 0);
    chk("R11", "upParentTag", int'(upParentTag), eFwd ? mTag[0] : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    clearModel();
    doReset();
    // R1: reset state
    chk("R1", "dnClaim", int'(dnClaim), 0);
    chk("R1", "upFwd", int'(upFwd), 0);
    chk("R1", "errors", int'(errDup) + int'(errSpace) + int'(errDmaSpace) + int'(errSelfDma), 0);
    for (int a = 0; a <= AMASK; a++) doDn(a, 1, "R1");
    // R10 gate: unconfigured memory window never refuses
    doUp(0, 'h3F0, 5);

    // R4: bad indices, R2: loads, R3: duplicate
    for (int idx = 4; idx < 8; idx++) doCfg(idx, 'h000, 0, 'h3FF, 1);
    doCfg(0, 'h100, 'h3E0, 'h80, 5);
    doCfg(1, 'h300, 'h010, 'h40, 2);
    doCfg(2, 'h3C0, 'h000, 'h40, 3);
    doCfg(3, 'h120, 'h200, 'h20, 6);
    doCfg(0, 'h000, 'h000, 'h3FF, 7);

    // R6: overlap goes to memory space; R5: top edge no wrap
    doDn('h120, 4, "R6");
    doDn('h3F1, 15, "R5");
    doDn('h3F2, 15, "R5");
    doDn('h17F, 1, "R5");
    doDn('h180, 1, "R5");

    // sweep downstream
    for (int a = 0; a <= AMASK; a++) begin
      doDn(a, 0, "");
      doDn(a, 1, "");
      doDn(a, 7, "");
      doDn(a, 15, "");
    end

    // sweep upstream
    for (int a = 0; a <= AMASK; a++)
      for (int sp = 0; sp < 4; sp++) begin
        doUp(sp, a, 0);
        doUp(sp, a, 15);
      end

    // R12: idle cycle after traffic
    @(negedge clk);
    chk("R12", "dnClaim idle", int'(dnClaim), 0);
    chk("R12", "upFwd idle", int'(upFwd), 0);
    chk("R12", "errors idle", int'(errDup) + int'(errSpace) + int'(errDmaSpace) + int'(errSelfDma), 0);

    // R1: second reset clears the table
    doReset();
    doDn('h120, 4, "R1");
    doDn('h3C0, 4, "R1");
    doCfg(0, 'h200, 'h000, 'h10, 4);
    doDn('h205, 2, "");
    doUp(0, 'h300, 3);

    finishRun();
  end
endmodule